// File: doc/BRIEF.md
# Token-Ring Cascaded FIFO

This block builds one deep first-in first-out buffer out of several identical small FIFO slices joined in a ring. The write data, read data, write enable, read enable and reset are shared by every slice. Only one slice at a time accepts writes: the one that holds the write token. Only one slice at a time delivers reads: the one that holds the read token. When a slice fills its last physical location, it hands the write token to the next slice in the ring. When it empties its last physical location, it hands the read token on in the same way. No logic outside the ring decides which slice is active.

After reset, a per-slice first-load input picks the slice that starts with both tokens. The tokens travel as single-cycle pulses on two separate link wires from each slice to its successor, and the last slice links back to the first.

The read data seen by the user comes from the slice that made the most recent read. The composite empty flag is the empty flag of the slice that holds the read token. The composite full flag is the full flag of the slice that holds the write token. The total capacity is the slice count times the slice depth.

Top module: `fifo_cascade_ring`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets: after that edge `empty` is 1, `full` is 0 and `rd_data` is 0.
- R2: Words are read out in the order they were written, including across slice boundaries and when the ring wraps back to the first slice.
- R3: With no reads, `full` stays 0 after N_SLICES*SLICE_DEPTH-1 writes and is 1 after N_SLICES*SLICE_DEPTH writes; `empty` and `full` are never 1 together.
- R4: A write while `full` is 1 is dropped: the stored contents are unchanged, `full` stays 1, and exactly N_SLICES*SLICE_DEPTH reads are needed to drain the buffer.
- R5: A read while `empty` is 1 is dropped: `rd_data` keeps the last word read and `empty` stays 1.
- R6: Exactly one slice holds the write token and exactly one holds the read token at every cycle after reset. A slice passes a token to its successor on the same clock edge that writes or reads its last location, so the next operation uses the successor.
- R7: When a write and a read are requested in the same cycle while `full` is 1, the read completes and the write is dropped, because `full` gates the write before the read frees a location.
- R8: The slice whose bit of `first_load_n` is 0 during reset holds both tokens in the first cycle after reset. Bit i of `first_load_n` belongs to slice i, and exactly one bit must be 0.
- R9: A read accepted at a clock edge (`rd_en` 1 and `empty` 0) places the oldest word on `rd_data` right after that edge, and the word stays there until the next accepted read.
- R10: A write accepted at a clock edge while `empty` is 1 makes `empty` 0 right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all slices |
| rst_n | input | 1 | Synchronous active-low reset |
| first_load_n | input | N_SLICES | Per-slice first-load select; a 0 bit marks the starting token holder |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered read data from the last slice that read |
| empty | output | 1 | Composite empty: read-token slice is empty |
| full | output | 1 | Composite full: write-token slice is full |

## Verification
Several properties are checked on every cycle: each token has exactly one owner, a write-token pulse moves the token, the two composite flags are never both set, a full buffer stays full when a write arrives without a read, an empty read leaves the output alone, and the reset token placement follows the first-load vector. Only the directed scenarios can show that data keeps its order across slice boundaries and ring wraps, and that the capacity is exact. They also show what happens when a read and a write arrive together at the full boundary, and that a different starting slice behaves the same at the ports.

// File: rtl/fifo_ring_pkg.sv
// Package: helpers shared by the ring FIFO modules.
// Assumes: depths are at least 1.
package fifo_ring_pkg;
    // Width of an index into a memory of the given depth (at least 1 bit).
    function automatic int ptr_w(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Width of an occupancy counter that must hold 0..depth.
    function automatic int cnt_w(input int depth);
        return $clog2(depth + 1);
    endfunction
endpackage

// File: rtl/fifo_ring_slice.sv
// Module: one slice of the token-ring FIFO.
// Holds SLICE_DEPTH words in a circular memory. It writes only while it owns
// the write token and reads only while it owns the read token. When it touches
// its last location it pulses the matching expansion-out wire, and the successor
// takes the token on the same edge.
// Assumes: wr_go / rd_go are already gated by the composite flags.
module fifo_ring_slice
    import fifo_ring_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SLICE_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first_load_n,
    input  logic              wr_go,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_go,
    input  logic              xi_wr,
    input  logic              xi_rd,
    output logic              xo_wr,
    output logic              xo_rd,
    output logic              wr_tok,
    output logic              rd_tok,
    output logic              s_empty,
    output logic              s_full,
    output logic              rd_fire,
    output logic [DATA_W-1:0] q
);
    localparam int AW = ptr_w(SLICE_DEPTH);
    localparam int CW = cnt_w(SLICE_DEPTH);
    localparam logic [AW-1:0] LAST = AW'(SLICE_DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(SLICE_DEPTH);

    logic [DATA_W-1:0] mem [SLICE_DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic [CW-1:0]     cnt;
    logic              do_wr, do_rd;

    // Local operation strobes and token-out pulses.
    always_comb begin
        do_wr   = wr_tok & wr_go & ~s_full;
        do_rd   = rd_tok & rd_go & ~s_empty;
        xo_wr   = do_wr & (wptr == LAST);
        xo_rd   = do_rd & (rptr == LAST);
        rd_fire = do_rd;
    end

    assign s_empty = (cnt == '0);
    assign s_full  = (cnt == CAP);

    // Token ownership: reset from first-load, gain on xi, lose on own xo.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_tok <= ~first_load_n;
            rd_tok <= ~first_load_n;
        end else begin
            if (xi_wr)      wr_tok <= 1'b1;
            else if (xo_wr) wr_tok <= 1'b0;
            if (xi_rd)      rd_tok <= 1'b1;
            else if (xo_rd) rd_tok <= 1'b0;
        end
    end

    // Pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Storage array write port.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_data;
    end

    // Registered read data of this slice.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (do_rd) q <= mem[rptr];
    end
endmodule

// File: rtl/fifo_ring_outsel.sv
// Module: AND-OR selector for the shared read bus.
// Passes the data of the slice whose select bit is set; all zero when none is.
// Assumes: sel is one-hot or zero.
module fifo_ring_outsel #(
    parameter int N_SLICES = 3,
    parameter int DATA_W   = 8
) (
    input  logic [N_SLICES-1:0]        sel,
    input  logic [N_SLICES*DATA_W-1:0] din,
    output logic [DATA_W-1:0]          dout
);
    // OR together each slice's data masked by its select bit.
    always_comb begin
        dout = '0;
        for (int i = 0; i < N_SLICES; i++) begin
            dout = dout | (din[i*DATA_W +: DATA_W] & {DATA_W{sel[i]}});
        end
    end
endmodule

// File: rtl/fifo_cascade_ring.sv
// Module: deep FIFO built from N_SLICES slices joined in a token ring.
// Each slice's expansion-out links to the next slice's expansion-in, with the
// last wrapping to the first; write and read tokens use separate links.
// The composite flags come from the token holders, and the output bus shows the
// slice that made the most recent read.
// Assumes: exactly one bit of first_load_n is 0 during reset.
module fifo_cascade_ring #(
    parameter int N_SLICES    = 3,
    parameter int SLICE_DEPTH = 4,
    parameter int DATA_W      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SLICES-1:0] first_load_n,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_en,
    output logic [DATA_W-1:0]   rd_data,
    output logic                empty,
    output logic                full
);
    logic [N_SLICES-1:0]        xo_wr_v, xo_rd_v, xi_wr_v, xi_rd_v;
    logic [N_SLICES-1:0]        wr_tok_v, rd_tok_v, empty_v, full_v, fire_v;
    logic [N_SLICES*DATA_W-1:0] q_flat;
    logic [N_SLICES-1:0]        last_rd;
    logic                       wr_go, rd_go;

    // Composite flags from the current token holders.
    always_comb begin
        empty = |(rd_tok_v & empty_v);
        full  = |(wr_tok_v & full_v);
        wr_go = wr_en & ~full;
        rd_go = rd_en & ~empty;
    end

    for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
        localparam int PREV = (i + N_SLICES - 1) % N_SLICES;
        assign xi_wr_v[i] = xo_wr_v[PREV];
        assign xi_rd_v[i] = xo_rd_v[PREV];

        fifo_ring_slice #(.DATA_W(DATA_W), .SLICE_DEPTH(SLICE_DEPTH)) u_slice (
            .clk          (clk),
            .rst_n        (rst_n),
            .first_load_n (first_load_n[i]),
            .wr_go        (wr_go),
            .wr_data      (wr_data),
            .rd_go        (rd_go),
            .xi_wr        (xi_wr_v[i]),
            .xi_rd        (xi_rd_v[i]),
            .xo_wr        (xo_wr_v[i]),
            .xo_rd        (xo_rd_v[i]),
            .wr_tok       (wr_tok_v[i]),
            .rd_tok       (rd_tok_v[i]),
            .s_empty      (empty_v[i]),
            .s_full       (full_v[i]),
            .rd_fire      (fire_v[i]),
            .q            (q_flat[i*DATA_W +: DATA_W])
        );
    end

    // Remember which slice drives the shared output bus.
    always_ff @(posedge clk) begin
        if (!rst_n)       last_rd <= '0;
        else if (|fire_v) last_rd <= fire_v;
    end

    fifo_ring_outsel #(.N_SLICES(N_SLICES), .DATA_W(DATA_W)) u_outsel (
        .sel  (last_rd),
        .din  (q_flat),
        .dout (rd_data)
    );
endmodule

// File: rtl/fifo_ring_chk.sv
// Module: protocol checker for the token-ring FIFO, bound to the top module.
// Assumes: synchronous active-low reset; tokens observed through the top's vectors.
module fifo_ring_chk #(
    parameter int N_SLICES = 3,
    parameter int DATA_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_SLICES-1:0] first_load_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [DATA_W-1:0]   rd_data,
    input logic                empty,
    input logic                full,
    input logic [N_SLICES-1:0] wr_tok,
    input logic [N_SLICES-1:0] rd_tok,
    input logic [N_SLICES-1:0] xo_wr
);
    p_one_wr_token_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_tok) == 1);

    p_one_rd_token_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_tok) == 1);

    p_wr_token_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((N_SLICES > 1) && (|xo_wr)) |=> (wr_tok != $past(wr_tok)));

    p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    p_full_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> full);

    p_empty_read_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en) |=> $stable(rd_data));

    p_reset_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((wr_tok == ~first_load_n) && (rd_tok == ~first_load_n)));
endmodule

bind fifo_cascade_ring fifo_ring_chk #(.N_SLICES(N_SLICES), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .first_load_n (first_load_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .empty        (empty),
    .full         (full),
    .wr_tok       (wr_tok_v),
    .rd_tok       (rd_tok_v),
    .xo_wr        (xo_wr_v)
);

// File: tb/test_fifo_cascade_ring.sv
// Directed bench for fifo_cascade_ring: one task per scenario.
module test_fifo_cascade_ring;
    localparam int CLK_P = 10;
    localparam int NS    = 3;
    localparam int SD    = 4;
    localparam int DW    = 8;
    localparam int CAP   = NS * SD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] first_load_n = 3'b110;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          empty, full;

    int n_run = 0;
    int n_fail = 0;

    fifo_cascade_ring #(.N_SLICES(NS), .SLICE_DEPTH(SD), .DATA_W(DW)) i_fifo_cascade_ring (
        .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .empty(empty), .full(full)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: inputs change at negedge, results sampled at the next negedge.
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push(input logic [DW-1:0] d);
        wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0;
    endtask

    task automatic pop_expect(input logic [DW-1:0] exp, input string req);
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        check(rd_data == exp, req, rd_data, exp);
    endtask

    task automatic do_reset(input logic [NS-1:0] fl);
        first_load_n = fl; rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    // R1: reset state.
    task automatic t_reset();
        do_reset(3'b110);
        check(empty == 1'b1, "R1 empty", empty, 1);
        check(full == 1'b0, "R1 full", full, 0);
        check(rd_data == '0, "R1 rd_data", rd_data, 0);
    endtask

    // R2, R9, R10: order across a slice boundary.
    task automatic t_order();
        push(8'h10);
        check(empty == 1'b0, "R10 empty clears after write", empty, 0);
        for (int i = 1; i < 6; i++) push(8'h10 + 8'(i));
        for (int i = 0; i < 6; i++) pop_expect(8'h10 + 8'(i), "R2 order");
        tick();
        check(rd_data == 8'h15, "R9 data held", rd_data, 8'h15);
        check(empty == 1'b1, "R2 empty after drain", empty, 1);
    endtask

    // R3, R4: exact capacity and dropped write while full.
    task automatic t_fill();
        for (int i = 0; i < CAP - 1; i++) push(8'h40 + 8'(i));
        check(full == 1'b0, "R3 not full at CAP-1", full, 0);
        push(8'h40 + 8'(CAP - 1));
        check(full == 1'b1, "R3 full at CAP", full, 1);
        check(empty == 1'b0, "R3 not empty when full", empty, 0);
        push(8'hEE);
        check(full == 1'b1, "R4 full stays", full, 1);
        for (int i = 0; i < CAP; i++) pop_expect(8'h40 + 8'(i), "R4 contents kept");
        check(empty == 1'b1, "R4 empty after CAP reads", empty, 1);
    endtask

    // R5: read while empty is ignored.
    task automatic t_empty_read();
        pop_expect(8'h40 + 8'(CAP - 1), "R5 rd_data holds");
        check(empty == 1'b1, "R5 empty stays", empty, 1);
    endtask

    // R7: simultaneous read and write at full.
    task automatic t_simul_full();
        for (int i = 0; i < CAP; i++) push(8'h80 + 8'(i));
        wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'h77; tick();
        wr_en = 1'b0; rd_en = 1'b0;
        check(rd_data == 8'h80, "R7 read done", rd_data, 8'h80);
        check(full == 1'b0, "R7 write dropped", full, 0);
        for (int i = 1; i < CAP; i++) pop_expect(8'h80 + 8'(i), "R7 remaining");
        check(empty == 1'b1, "R7 no extra word", empty, 1);
    endtask

    // R6, R8: other starting slice, streaming through several ring wraps.
    task automatic t_start_and_wrap();
        do_reset(3'b011);
        check(empty == 1'b1, "R8 empty after reset", empty, 1);
        push(8'h01); push(8'h02);
        for (int i = 0; i < 3 * CAP; i++) begin
            wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'h03 + 8'(i); tick();
            wr_en = 1'b0; rd_en = 1'b0;
            check(rd_data == 8'h01 + 8'(i), "R6 wrap order", rd_data, 8'h01 + 8'(i));
        end
        pop_expect(8'h01 + 8'(3 * CAP), "R8 tail");
        pop_expect(8'h02 + 8'(3 * CAP), "R8 tail");
        check(empty == 1'b1, "R6 drained", empty, 1);
    endtask

    bit done = 1'b0;

    initial begin
        tick();
        t_reset();
        t_order();
        t_fill();
        t_empty_read();
        t_simul_full();
        t_start_and_wrap();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule